// File: doc/BRIEF.md
# CGMS Word Formatter with Check Sequence and Field Gating

This block builds the 20-bit copy generation management word that is inserted on one line of an NTSC picture. It then shifts that word out one bit at a time. It also decides whether wide screen signalling is active, which applies only to PAL. The word has 14 data bits followed by a 6-bit check sequence. The block can compute the check sequence itself or take it unchanged from a register field.

Upstream logic presents the data bits, the control byte, the video standard and the parity of the current field. A line-timing source pulses `line_start` on the insertion line. A bit-period source pulses `bit_tick` once for each transmitted bit. When the standard and the field enables allow it, the word is captured on `line_start`. It is then presented on `cgms_bit` with `cgms_valid` high until the last bit has been consumed.

Top module: `cgms_formatter`

## Requirements
- R1: After reset, `cgms_valid`, `cgms_bit` and `cgms_done` are 0, and `wss_en` is 0 while `ctrl_reg` is 0.
- R2: A captured word is 20 bits, sent first-to-last in this order: `data_hi[0]` to `data_hi[9]`, then `ctrl_reg[0]` to `ctrl_reg[3]` as the final four data bits, then six check bits.
- R3: When `ctrl_reg[4]` is 1, the check bits are the remainder of a bit-serial division of the 14 data bits, taken in send order, by x^6 + x + 1. The six-stage remainder register starts at all ones. The highest stage is sent first.
- R4: When `ctrl_reg[4]` is 0, the check bits are `manual_crc` sent unchanged, `manual_crc[5]` first.
- R5: In NTSC (`std_pal` = 0), a `line_start` in an odd field (`field_odd` = 1) starts a word only when `ctrl_reg[5]` is 1.
- R6: In NTSC, a `line_start` in an even field (`field_odd` = 0) starts a word only when `ctrl_reg[6]` is 1.
- R7: In PAL (`std_pal` = 1), `line_start` never starts a word, whatever the field enables are set to.
- R8: `wss_en` is 1 exactly when `std_pal` is 1 and `ctrl_reg[7]` is 1. In NTSC, `ctrl_reg[7]` has no effect.
- R9: `cgms_valid` rises in the cycle after an accepted `line_start`. The bit on `cgms_bit` advances only on a cycle with `bit_tick` high, and it holds otherwise.
- R10: In the cycle after the 20th tick, `cgms_valid` falls and `cgms_done` is high for exactly one cycle.
- R11: A `line_start` while a word is being sent is ignored. Input changes during sending do not alter the remaining bits.
- R12: While `cgms_valid` is 0, `cgms_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_reg | input | 8 | Final data nibble [3:0], internal check select [4], odd-field enable [5], even-field enable [6], WSS enable [7] |
| data_hi | input | 10 | First ten data bits, bit 0 sent first |
| manual_crc | input | 6 | Check bits used when internal generation is off |
| std_pal | input | 1 | 1 = PAL, 0 = NTSC |
| field_odd | input | 1 | 1 = odd field, 0 = even field |
| line_start | input | 1 | Pulse on the insertion line |
| bit_tick | input | 1 | One pulse per bit period |
| cgms_bit | output | 1 | Serial word bit |
| cgms_valid | output | 1 | High while a word is on `cgms_bit` |
| cgms_done | output | 1 | One-cycle pulse after the last bit |
| wss_en | output | 1 | Wide screen signalling active |

## Verification
A corrupted remainder register shows up only in the last six bits of a word. The first such bit appears 14 ticks after launch, so the bench compares every bit of every word against an independent model. It uses many random data words so that single-stage errors reach the output. A wrong bit counter moves the fall of `cgms_valid` and the `cgms_done` pulse away from the cycle after the 20th tick, and the bench sees this on the first word. A wrong gating term shows one cycle after `line_start`, as a `cgms_valid` that rises when it should not or stays low when it should rise.

// File: rtl/cgms_pkg.sv
package cgms_pkg;
   typedef enum logic {
      STD_NTSC = 1'b0,
      STD_PAL  = 1'b1
   } video_std_e;

   localparam int unsigned CTRL_NIBBLE_W = 4;
   localparam int unsigned CTRL_CRC_SEL  = 4;
   localparam int unsigned CTRL_EN_ODD   = 5;
   localparam int unsigned CTRL_EN_EVEN  = 6;
   localparam int unsigned CTRL_EN_WSS   = 7;
endpackage

// File: rtl/cgms_crc.sv
module cgms_crc #(
   parameter int unsigned       DATA_W = 14,
   parameter int unsigned       CRC_W  = 6,
   parameter logic [CRC_W-1:0]  POLY   = 6'b000011,
   parameter logic [CRC_W-1:0]  INIT   = '1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  rem_o
);
   generate
      if (CRC_W < 2) begin : g_bad_w
         $error("cgms_crc: CRC_W must be at least 2");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("cgms_crc: generator must include the x^0 term");
      end
   endgenerate

   always_comb begin
      logic [CRC_W-1:0] r;
      logic             fb;
      r = INIT;
      for (int i = 0; i < DATA_W; i++) begin
         fb = data_i[i] ^ r[CRC_W-1];
         r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      rem_o = r;
   end
endmodule

// File: rtl/cgms_gate.sv
module cgms_gate
   import cgms_pkg::*;
(
   input  logic std_pal,
   input  logic field_odd,
   input  logic en_odd,
   input  logic en_even,
   input  logic en_wss,
   output logic cgms_ok,
   output logic wss_on
);
   video_std_e std;

   always_comb begin
      std     = video_std_e'(std_pal);
      cgms_ok = (std == STD_NTSC) && (field_odd ? en_odd : en_even);
      wss_on  = (std == STD_PAL) && en_wss;
   end
endmodule

// File: rtl/cgms_serializer.sv
module cgms_serializer #(
   parameter int unsigned WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              tick_i,
   output logic              bit_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   generate
      if (WORD_W < 2) begin : g_bad_w
         $error("cgms_serializer: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (load_i) begin
               sh_q   <= word_i;
               cnt_q  <= '0;
               busy_q <= 1'b1;
            end
         end else if (tick_i) begin
            sh_q <= sh_q >> 1;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign bit_o  = busy_q & sh_q[0];
   assign busy_o = busy_q;
   assign done_o = done_q;

   // R10
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && $past(busy_q) && $past(tick_i)));

   // R9
   hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$past(tick_i)) |-> $stable(bit_o));

   // R10
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= LAST));
endmodule

// File: rtl/cgms_formatter.sv
module cgms_formatter
   import cgms_pkg::*;
#(
   parameter int unsigned      DATA_W = 14,
   parameter int unsigned      CRC_W  = 6,
   parameter logic [CRC_W-1:0] POLY   = 6'b000011,
   parameter logic [CRC_W-1:0] INIT   = '1,
   localparam int unsigned     HI_W   = DATA_W - CTRL_NIBBLE_W,
   localparam int unsigned     WORD_W = DATA_W + CRC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       ctrl_reg,
   input  logic [HI_W-1:0]  data_hi,
   input  logic [CRC_W-1:0] manual_crc,
   input  logic             std_pal,
   input  logic             field_odd,
   input  logic             line_start,
   input  logic             bit_tick,
   output logic             cgms_bit,
   output logic             cgms_valid,
   output logic             cgms_done,
   output logic             wss_en
);
   generate
      if (DATA_W <= CTRL_NIBBLE_W) begin : g_bad_data
         $error("cgms_formatter: DATA_W must exceed the register nibble");
      end
   endgenerate

   logic [DATA_W-1:0] data_w;
   logic [CRC_W-1:0]  gen_rem;
   logic [CRC_W-1:0]  sel_rem;
   logic [WORD_W-1:0] word_w;
   logic              allow;

   assign data_w  = {ctrl_reg[CTRL_NIBBLE_W-1:0], data_hi};
   assign sel_rem = ctrl_reg[CTRL_CRC_SEL] ? gen_rem : manual_crc;

   cgms_crc #(
      .DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .INIT(INIT)
   ) u_crc (
      .data_i(data_w),
      .rem_o (gen_rem)
   );

   assign word_w[DATA_W-1:0] = data_w;
   generate
      for (genvar k = 0; k < CRC_W; k++) begin : g_crc_order
         assign word_w[DATA_W + k] = sel_rem[CRC_W - 1 - k];
      end
   endgenerate

   cgms_gate u_gate (
      .std_pal  (std_pal),
      .field_odd(field_odd),
      .en_odd   (ctrl_reg[CTRL_EN_ODD]),
      .en_even  (ctrl_reg[CTRL_EN_EVEN]),
      .en_wss   (ctrl_reg[CTRL_EN_WSS]),
      .cgms_ok  (allow),
      .wss_on   (wss_en)
   );

   cgms_serializer #(.WORD_W(WORD_W)) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(line_start & allow),
      .word_i(word_w),
      .tick_i(bit_tick),
      .bit_o (cgms_bit),
      .busy_o(cgms_valid),
      .done_o(cgms_done)
   );

   // R7
   pal_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cgms_valid) |-> $past(!std_pal && line_start));

   // R5
   field_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cgms_valid) |->
         $past(field_odd ? ctrl_reg[CTRL_EN_ODD] : ctrl_reg[CTRL_EN_EVEN]));

   // R10
   fall_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cgms_valid) |-> cgms_done);
endmodule

// File: tb/tb_cgms_formatter.sv
`timescale 1ns/1ps
module tb_cgms_formatter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ctrl_reg = '0;
   logic [9:0] data_hi = '0;
   logic [5:0] manual_crc = '0;
   logic       std_pal = 1'b0;
   logic       field_odd = 1'b1;
   logic       line_start = 1'b0;
   logic       bit_tick = 1'b0;
   logic       cgms_bit, cgms_valid, cgms_done, wss_en;

   int n_chk = 0;
   int n_fail = 0;
   logic exp_q[$];
   string cur_tag = "R2";

   always #2.5 clk = ~clk;

   cgms_formatter dut (
      .clk(clk), .rst_n(rst_n), .ctrl_reg(ctrl_reg), .data_hi(data_hi),
      .manual_crc(manual_crc), .std_pal(std_pal), .field_odd(field_odd),
      .line_start(line_start), .bit_tick(bit_tick), .cgms_bit(cgms_bit),
      .cgms_valid(cgms_valid), .cgms_done(cgms_done), .wss_en(wss_en)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] model_rem(input logic [13:0] d);
      logic [5:0] r = 6'b111111;
      for (int i = 0; i < 14; i++) begin
         logic top = r[5];
         logic in  = d[i];
         r = {r[4:1], r[0] ^ (in ^ top), in ^ top};
      end
      return r;
   endfunction

   task automatic tick_cycle(input logic t);
      bit_tick = t;
      @(posedge clk); #1;
   endtask

   // gap_every: 0 = tick every cycle; restart_at: bit index for a second line_start (-1 none)
   task automatic send_word(input logic [9:0] hi, input logic [7:0] ctl, input logic [5:0] man,
                            input logic odd, input int gap_every, input int restart_at, input string tag);
      logic [13:0] d;
      logic [5:0]  rem;
      d   = {ctl[3:0], hi};
      rem = ctl[4] ? model_rem(d) : man;
      cur_tag = tag;
      for (int i = 0; i < 14; i++) exp_q.push_back(d[i]);
      for (int k = 0; k < 6; k++) exp_q.push_back(rem[5-k]);
      ctrl_reg = ctl; data_hi = hi; manual_crc = man; std_pal = 1'b0; field_odd = odd;
      line_start = 1'b1;
      @(posedge clk); #1;
      line_start = 1'b0;
      for (int b = 0; b < 20; b++) begin
         if (b == restart_at) begin
            // R11: new request and changed inputs while sending
            line_start = 1'b1;
            data_hi = ~hi; ctrl_reg = ctl ^ 8'h1F; manual_crc = ~man;
            tick_cycle(1'b0);
            line_start = 1'b0;
         end
         if (gap_every != 0 && (b % gap_every) == 1) tick_cycle(1'b0);
         tick_cycle(1'b1);
      end
      bit_tick = 1'b0;
      @(negedge clk);
      chk(cgms_done === 1'b1, "R10 done after 20th tick", int'(cgms_done), 1);
      chk(cgms_valid === 1'b0, "R10 valid falls", int'(cgms_valid), 0);
      chk(exp_q.size() == 0, "R2 word length", exp_q.size(), 0);
      @(posedge clk); #1;
      @(negedge clk);
      chk(cgms_done === 1'b0, "R10 done one cycle", int'(cgms_done), 0);
      chk(cgms_bit === 1'b0, "R12 idle bit low", int'(cgms_bit), 0);
      exp_q.delete();
   endtask

   task automatic expect_no_launch(input logic [7:0] ctl, input logic pal, input logic odd, input string tag);
      ctrl_reg = ctl; std_pal = pal; field_odd = odd;
      data_hi = 10'h3FF;
      line_start = 1'b1;
      @(posedge clk); #1;
      line_start = 1'b0;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk(cgms_valid === 1'b0, tag, int'(cgms_valid), 0);
         chk(cgms_bit === 1'b0, "R12 no output while idle", int'(cgms_bit), 0);
         bit_tick = 1'b1;
         @(posedge clk); #1;
         bit_tick = 1'b0;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && cgms_valid) begin
         if (bit_tick) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected bit", int'(cgms_bit), -1);
            end else begin
               logic e;
               int   idx;
               idx = 20 - exp_q.size();
               e = exp_q.pop_front();
               chk(cgms_bit === e, (idx < 14) ? "R2 data bit" : cur_tag, int'(cgms_bit), int'(e));
            end
         end else if (exp_q.size() > 0) begin
            chk(cgms_bit === exp_q[0], "R9 hold without tick", int'(cgms_bit), int'(exp_q[0]));
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1
      chk(cgms_valid === 1'b0, "R1 reset valid", int'(cgms_valid), 0);
      chk(cgms_bit === 1'b0, "R1 reset bit", int'(cgms_bit), 0);
      chk(cgms_done === 1'b0, "R1 reset done", int'(cgms_done), 0);
      chk(wss_en === 1'b0, "R1 reset wss", int'(wss_en), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R3 internal check over random words, odd field (R5)
      for (int n = 0; n < 12; n++) begin
         logic [13:0] r = 14'($urandom);
         send_word(r[9:0], {4'b0011, r[13:10]}, 6'($urandom), 1'b1, 0, -1, "R3 internal check bit");
      end
      send_word(10'h000, 8'h30, 6'h00, 1'b1, 0, -1, "R3 all-zero data");
      send_word(10'h3FF, 8'h3F, 6'h00, 1'b1, 0, -1, "R3 all-one data");

      // R4 manual pass-through
      send_word(10'h155, 8'h2A, 6'h2D, 1'b1, 0, -1, "R4 manual check bit");
      send_word(10'h0F0, 8'h23, 6'h01, 1'b1, 0, -1, "R4 manual check bit");
      send_word(10'h2C3, 8'h2C, 6'h3E, 1'b1, 3, -1, "R4 manual check bit");

      // R6 even field
      send_word(10'h1A5, 8'h5B, 6'h00, 1'b0, 0, -1, "R6 even field word");
      // R5/R6 wrong-field enables
      expect_no_launch(8'h50, 1'b0, 1'b1, "R5 odd field disabled");
      expect_no_launch(8'h30, 1'b0, 1'b0, "R6 even field disabled");

      // R7 PAL blocks both enables
      expect_no_launch(8'h70, 1'b1, 1'b1, "R7 PAL odd");
      expect_no_launch(8'h70, 1'b1, 1'b0, "R7 PAL even");

      // R8 wide screen enable
      ctrl_reg = 8'h80; std_pal = 1'b1;
      @(negedge clk);
      chk(wss_en === 1'b1, "R8 PAL wss on", int'(wss_en), 1);
      ctrl_reg = 8'h00;
      @(negedge clk);
      chk(wss_en === 1'b0, "R8 PAL wss off", int'(wss_en), 0);
      ctrl_reg = 8'h80; std_pal = 1'b0;
      @(negedge clk);
      chk(wss_en === 1'b0, "R8 NTSC ignores wss", int'(wss_en), 0);
      @(posedge clk); #1;

      // R9 gaps and R11 restart ignored
      send_word(10'h2B7, 8'h39, 6'h00, 1'b1, 2, -1, "R9 gapped ticks");
      send_word(10'h1C4, 8'h36, 6'h00, 1'b1, 0, 10, "R11 restart ignored");
      send_word(10'h3A1, 8'h25, 6'h15, 1'b1, 0, 17, "R11 restart ignored");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule